// File: doc/BRIEF.md
# Calendar alarm matcher

This block watches a running calendar, delivered as seven BCD fields (seconds, minutes, hours, weekday, day of month, month, year), and compares it with a programmed alarm time. Each alarm field carries its own match enable, so software can build alarms such as "every day at 07:30:00" by enabling only the seconds, minutes and hours fields. Timekeeping itself is done elsewhere. The block only compares the time it is given, once per second tick.

Software writes alarm values into staging registers over a 16-bit register port. It then writes the commit register with bit 15 set, which copies the whole staged set into the active comparator in one step. A match sets a sticky status bit. The interrupt line is that status bit gated by an interrupt-enable bit. The status bit is cleared by writing 1 to it.

Top module: `cal_alarm_match`

Register map (4-bit address). Addresses 0 to 6 hold the staged fields in the order seconds, minutes, hours, weekday, day, month, year. Their field widths are 7, 7, 6, 3, 6, 5 and 8 bits. Bit 15 of each is the field's match enable, and the value sits in the low bits. Address 7 is the commit register. Address 8 holds the interrupt enable in bit 0. Address 9 holds the status in bit 0.

## Requirements
- R1: After reset, every field register, the interrupt-enable register and the status register read 0, and irq_o is 0.
- R2: Writes to the staged field registers (addresses 0 to 6) do not affect matching until a write to address 7 with bit 15 set. A write to address 7 with bit 15 clear commits nothing.
- R3: The status bit (address 9, bit 0) is set at the clock edge where tick_i is high and every enabled active field equals its time input. Without tick_i, the status bit is never set.
- R4: A field whose enable (bit 15) is 0 takes no part in the comparison, whatever its value. The weekday field can be left disabled while all other fields are enabled.
- R5: When no field is enabled, no match occurs on any tick.
- R6: irq_o is high exactly while the status bit and the interrupt enable (address 8, bit 0) are both 1. The status bit stays set until it is cleared.
- R7: Writing address 9 with bit 0 set clears the status bit, and writing it with bit 0 clear has no effect. A match on the same edge as a clear leaves the status bit set.
- R8: A read of a field register returns its staged enable in bit 15 and its staged value in the low bits of that field's width, with every other bit 0. For example, writing 16'hFFFF to the weekday register reads back 16'h8007.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational on address) |
| tick_i | input | 1 | One-cycle second tick |
| now_sec_i | input | 7 | Current seconds, BCD |
| now_min_i | input | 7 | Current minutes, BCD |
| now_hour_i | input | 6 | Current hours, BCD |
| now_wday_i | input | 3 | Current weekday |
| now_day_i | input | 6 | Current day of month, BCD |
| now_mon_i | input | 5 | Current month, BCD |
| now_year_i | input | 8 | Current year, BCD |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Register writes, commits and status clears all take effect at the clock edge on which the strobe is high. The status bit is set at the edge on which tick_i is high, and irq_o follows it with no extra register, while read data is combinational on the address. The bench drives every stimulus on a falling edge, which puts exactly one rising edge between the stimulus and the following falling edge. It samples reads, status and irq_o just after that falling edge. A near-exhaustive sweep over all 128 field-enable masks, crossed with several patterns of mismatching fields and both interrupt-enable settings, compares status and interrupt against a result computed arithmetically from the mask.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NF        = 7;
  localparam int RW        = 16;
  localparam int AW        = 4;
  localparam int MAXW      = 8;
  localparam int A_COMMIT  = 7;
  localparam int A_IE      = 8;
  localparam int A_ST      = 9;

  function automatic int fld_w(input int i);
    case (i)
      0: return 7;
      1: return 7;
      2: return 6;
      3: return 3;
      4: return 6;
      5: return 5;
      default: return 8;
    endcase
  endfunction

  function automatic int fld_ofs(input int i);
    int s = 0;
    for (int k = 0; k < i; k++) s += fld_w(k);
    return s;
  endfunction

  localparam int TOT = fld_ofs(NF);
endpackage

// File: rtl/alarm_field_bank.sv
module alarm_field_bank
  import cal_alarm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NF-1:0]        fld_we_i,
  input  logic                 wr_en_bit_i,
  input  logic [MAXW-1:0]      wr_val_i,
  input  logic                 commit_i,
  output logic [NF-1:0]        stg_en_o,
  output logic [TOT-1:0]       stg_val_o,
  output logic [NF-1:0]        act_en_o,
  output logic [TOT-1:0]       act_val_o
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam int W = fld_w(i);
    localparam int O = fld_ofs(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_en_o[i]      <= 1'b0;
        stg_val_o[O+:W]  <= '0;
      end else if (fld_we_i[i]) begin
        stg_en_o[i]      <= wr_en_bit_i;
        stg_val_o[O+:W]  <= wr_val_i[W-1:0];
      end
    end
  end

  // whole staged set moves in one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en_o  <= '0;
      act_val_o <= '0;
    end else if (commit_i) begin
      act_en_o  <= stg_en_o;
      act_val_o <= stg_val_o;
    end
  end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import cal_alarm_pkg::*;
(
  input  logic                 tick_i,
  input  logic [NF-1:0]        act_en_i,
  input  logic [TOT-1:0]       act_val_i,
  input  logic [TOT-1:0]       now_i,
  output logic                 hit_o
);
  logic [NF-1:0] fld_ok;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    localparam int W = fld_w(i);
    localparam int O = fld_ofs(i);
    assign fld_ok[i] = !act_en_i[i] || (act_val_i[O+:W] == now_i[O+:W]);
  end

  assign hit_o = tick_i && (|act_en_i) && (&fld_ok);
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ie_we_i,
  input  logic ie_val_i,
  input  logic st_clr_i,
  input  logic hit_i,
  output logic ie_o,
  output logic st_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ie_o <= 1'b0;
    else if (ie_we_i) ie_o <= ie_val_i;
  end

  // set has priority over a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       st_o <= 1'b0;
    else if (hit_i)    st_o <= 1'b1;
    else if (st_clr_i) st_o <= 1'b0;
  end

  assign irq_o = st_o & ie_o;
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  input  logic          tick_i,
  input  logic [6:0]    now_sec_i,
  input  logic [6:0]    now_min_i,
  input  logic [5:0]    now_hour_i,
  input  logic [2:0]    now_wday_i,
  input  logic [5:0]    now_day_i,
  input  logic [4:0]    now_mon_i,
  input  logic [7:0]    now_year_i,
  output logic          irq_o
);
  logic [NF-1:0]  fld_we;
  logic           commit, ie_we, st_clr, hit, ie_q, st_q;
  logic [NF-1:0]  stg_en, act_en;
  logic [TOT-1:0] stg_val, act_val, now_vec;
  logic [RW-1:0]  fld_rd [NF];
  logic           wdata_unused;

  assign wdata_unused = ^reg_wdata_i[RW-2:MAXW];

  assign now_vec = {now_year_i, now_mon_i, now_day_i, now_wday_i,
                    now_hour_i, now_min_i, now_sec_i};

  for (genvar i = 0; i < NF; i++) begin : g_dec
    localparam int W = fld_w(i);
    localparam int O = fld_ofs(i);
    assign fld_we[i] = reg_we_i && (reg_addr_i == AW'(i));
    assign fld_rd[i] = {stg_en[i], (RW-1)'(stg_val[O+:W])};
  end

  assign commit = reg_we_i && (reg_addr_i == AW'(A_COMMIT)) && reg_wdata_i[RW-1];
  assign ie_we  = reg_we_i && (reg_addr_i == AW'(A_IE));
  assign st_clr = reg_we_i && (reg_addr_i == AW'(A_ST)) && reg_wdata_i[0];

  alarm_field_bank i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fld_we_i   (fld_we),
    .wr_en_bit_i(reg_wdata_i[RW-1]),
    .wr_val_i   (reg_wdata_i[MAXW-1:0]),
    .commit_i   (commit),
    .stg_en_o   (stg_en),
    .stg_val_o  (stg_val),
    .act_en_o   (act_en),
    .act_val_o  (act_val)
  );

  alarm_compare i_cmp (
    .tick_i   (tick_i),
    .act_en_i (act_en),
    .act_val_i(act_val),
    .now_i    (now_vec),
    .hit_o    (hit)
  );

  alarm_irq_ctrl i_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ie_we_i (ie_we),
    .ie_val_i(reg_wdata_i[0]),
    .st_clr_i(st_clr),
    .hit_i   (hit),
    .ie_o    (ie_q),
    .st_o    (st_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NF; i++)
      if (reg_addr_i == AW'(i)) reg_rdata_o = fld_rd[i];
    if (reg_addr_i == AW'(A_IE)) reg_rdata_o = {{(RW-1){1'b0}}, ie_q};
    if (reg_addr_i == AW'(A_ST)) reg_rdata_o = {{(RW-1){1'b0}}, st_q};
  end
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
  import cal_alarm_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          st_clr_i,
  input logic          hit_i,
  input logic [NF-1:0] act_en_i,
  input logic          status_i,
  input logic          ie_i,
  input logic          irq_i
);
  AST_SET_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i) |-> $past(tick_i)); // R3
  AST_HIT_SETS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> status_i); // R3
  AST_NO_ENABLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_en_i == '0) |-> !hit_i); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i && !st_clr_i) |=> status_i); // R6
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (status_i && ie_i)); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_clr_i && !hit_i) |=> !status_i); // R7
endmodule

bind cal_alarm_match cal_alarm_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .st_clr_i(st_clr),
  .hit_i   (hit),
  .act_en_i(act_en),
  .status_i(st_q),
  .ie_i    (ie_q),
  .irq_i   (irq_o)
);

// File: tb/test_cal_alarm_match.sv
module test_cal_alarm_match;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        tick_i = 1'b0;
  logic [7:0]  nowf [7];
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  int fw [7] = '{7, 7, 6, 3, 6, 5, 8};

  always #2 clk_i = ~clk_i;

  cal_alarm_match i_cal_alarm_match (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .tick_i,
    .now_sec_i (nowf[0][6:0]), .now_min_i(nowf[1][6:0]), .now_hour_i(nowf[2][5:0]),
    .now_wday_i(nowf[3][2:0]), .now_day_i(nowf[4][5:0]), .now_mon_i (nowf[5][4:0]),
    .now_year_i(nowf[6]), .irq_o
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 4'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_addr_i = 4'(a);
    #1 v = reg_rdata_o;
  endtask

  task automatic tick();
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  function automatic logic [7:0] fmask(input int i, input logic [7:0] v);
    return v & 8'((1 << fw[i]) - 1);
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  a [7];
    for (int i = 0; i < 7; i++) nowf[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int i = 0; i < 10; i++) begin rd(i, v); chk("R1 reset reg", v, 16'h0); end
    chk("R1 irq after reset", {15'b0, irq_o}, 16'h0);

    // R8 read-back masking
    wr(3, 16'hFFFF); rd(3, v); chk("R8 weekday readback", v, 16'h8007);
    wr(6, 16'h80A5); rd(6, v); chk("R8 year readback", v, 16'h80A5);
    wr(0, 16'h00FF); rd(0, v); chk("R8 seconds readback", v, 16'h007F);

    // R2 staged values inactive until commit
    for (int i = 0; i < 7; i++) begin
      a[i] = fmask(i, 8'(8'h15 + i * 8'h11));
      wr(i, {1'b1, 7'b0, a[i]});
      nowf[i] = a[i];
    end
    wr(8, 16'h0001);
    wr(7, 16'h7FFF);
    tick(); rd(9, v); chk("R2 commit without bit15", v, 16'h0);
    wr(7, 16'h8000);
    tick(); rd(9, v); chk("R3 full match sets status", v, 16'h1);
    chk("R6 irq with enable", {15'b0, irq_o}, 16'h1);

    // R6 gating and hold
    wr(8, 16'h0000); #1 chk("R6 irq gated off", {15'b0, irq_o}, 16'h0);
    wr(8, 16'h0001); #1 chk("R6 irq regated", {15'b0, irq_o}, 16'h1);
    repeat (5) @(negedge clk_i);
    chk("R6 irq holds", {15'b0, irq_o}, 16'h1);

    // R7 write-one-to-clear
    wr(9, 16'hFFFE); rd(9, v); chk("R7 write zero ignored", v, 16'h1);
    wr(9, 16'h0001); rd(9, v); chk("R7 write one clears", v, 16'h0);
    chk("R7 irq low after clear", {15'b0, irq_o}, 16'h0);

    // R2 staged change after commit does not disturb active alarm
    wr(0, {1'b1, 7'b0, fmask(0, a[0] ^ 8'h01)});
    tick(); rd(9, v); chk("R2 staged edit not active", v, 16'h1);
    wr(7, 16'h8000);
    tick(); rd(9, v); chk("R2 status stays set", v, 16'h1);
    wr(9, 16'h0001);
    tick(); rd(9, v); chk("R2 committed edit mismatches", v, 16'h0);
    wr(0, {1'b1, 7'b0, a[0]}); wr(7, 16'h8000);

    // R3 no tick no set
    repeat (6) @(negedge clk_i);
    rd(9, v); chk("R3 no tick no status", v, 16'h0);

    // R7 set wins over simultaneous clear
    @(negedge clk_i);
    tick_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 4'd9; reg_wdata_i = 16'h0001;
    @(negedge clk_i);
    tick_i = 1'b0; reg_we_i = 1'b0;
    rd(9, v); chk("R7 set beats clear", v, 16'h1);
    wr(9, 16'h0001);

    // R4 weekday disabled, all else enabled
    wr(3, 16'h0000); wr(7, 16'h8000);
    nowf[3] = fmask(3, a[3] ^ 8'h03);
    tick(); rd(9, v); chk("R4 weekday off ignored", v, 16'h1);
    wr(9, 16'h0001);

    // R3 R4 R5 R6 sweep over every enable mask
    for (int m = 0; m < 128; m++) begin
      for (int p = 0; p < 4; p++) begin
        logic [6:0] d;
        logic       ie, exp;
        case (p)
          0: d = 7'h00;
          1: d = 7'(1 << (m % 7));
          2: d = 7'h40;
          default: d = 7'h7F;
        endcase
        ie  = m[1] ^ p[0];
        exp = (m != 0) && ((7'(m) & d) == 0);
        wr(9, 16'h0001);
        for (int i = 0; i < 7; i++) begin
          a[i] = fmask(i, 8'(m * 3 + i * 29 + p));
          wr(i, {m[i], 7'b0, a[i]});
          nowf[i] = d[i] ? fmask(i, a[i] ^ 8'h01) : a[i];
        end
        wr(7, 16'h8000);
        wr(8, {15'b0, ie});
        tick();
        rd(9, v);
        chk($sformatf("R3 R4 R5 sweep m=%0d p=%0d status", m, p), v, {15'b0, exp});
        chk($sformatf("R6 sweep m=%0d p=%0d irq", m, p), {15'b0, irq_o}, {15'b0, exp & ie});
      end
    end

    summary();
  end
endmodule